// File: doc/BRIEF.md
# Quad-Linear Energy Sum Encoder

This block takes the three energy sums a processing module produces on every bunch-clock cycle: the scalar transverse energy ET and the two vector components EX and EY. It compresses each sum into an 8-bit quad-linear code. Each code holds a 6-bit mantissa and a 2-bit range. The four ranges step the resolution by factors of four, giving 1, 4, 16 and 64 GeV per count. Small sums keep full 1 GeV precision, and large sums still fit in eight bits.

The three codes are packed side by side into a 24-bit word. A parity bit is placed above them so that the 25-bit word always has odd weight. The result is registered once and drives a parallel backplane port.

EX and EY arrive as two's-complement values in quarter-GeV units. The block takes their magnitude, converts it to whole GeV by dropping the two fraction bits, and encodes the result. The sign is not transmitted. Any value too large for the coarsest range is clamped to the all-ones code.

Top module: `esum_qlin_packer`

## Requirements
- R1: ET (unsigned, 1 GeV per LSB) is encoded using the smallest range r in 0..3 for which floor(ET / 4^r) < 64. The mantissa is floor(ET / 4^r). In each 8-bit code, bits 5:0 hold the mantissa and bits 7:6 hold r.
- R2: EX and EY are two's-complement values with 0.25 GeV per LSB. Each is encoded as floor(|value| / 4) GeV using the rule of R1. The sign has no effect on the code.
- R3: A code with a nonzero range always has a mantissa of at least 16.
- R4: A GeV value of 4096 or more saturates to code 0xFF. With the default widths this can only occur if ET_W or XY_W is enlarged.
- R5: The ET code occupies word bits 7:0, the EX code bits 15:8, and the EY code bits 23:16.
- R6: Word bit 24 is set so that the full 25-bit word contains an odd number of ones.
- R7: The word present after a rising clock edge reflects the inputs sampled at that edge. Inputs that change between edges do not alter the word.
- R8: While rst_n is low at a rising edge, the word becomes 0x1000000 (three zero codes with the parity bit set), whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| et_in | input | ET_W (12) | Scalar energy sum, 1 GeV per LSB |
| ex_in | input | XY_W (14) | Signed X component, 0.25 GeV per LSB |
| ey_in | input | XY_W (14) | Signed Y component, 0.25 GeV per LSB |
| word_out | output | 25 | Packed codes with odd parity on bit 24 |

## Verification
On every cycle, the assertions check:
- the odd weight of the output word;
- that each of the three fields uses the smallest range that fits;
- the reset word;
- the exact pass-through of small ET values with one cycle of delay;
- that a zero EX input yields a zero EX field.

The exact mantissa at each range boundary, the treatment of negative EX and EY (including the most negative value and minus one), and saturation in a widened instance are shown only by the bench's scenarios. The bench compares the whole word against its behavioural model on every clock. It also confirms that the output holds steady between edges.

// File: rtl/esum_qlin_pkg.sv
// Package: shared constants and the code type for the quad-linear encoder.
// Assumes a 6-bit mantissa, a 2-bit range and a resolution step of 4x per range.
package esum_qlin_pkg;
    localparam int MANT_W     = 6;
    localparam int RANGE_W    = 2;
    localparam int N_RANGES   = 1 << RANGE_W;
    localparam int RANGE_STEP = 2;                 // shift bits per range (x4)
    localparam int CODE_W     = MANT_W + RANGE_W;
    localparam int N_SUMS     = 3;
    localparam int WORD_W     = N_SUMS * CODE_W + 1;

    typedef struct packed {
        logic [RANGE_W-1:0] rng;
        logic [MANT_W-1:0]  mant;
    } qcode_t;

    // Word driven while in reset: zero codes with the odd-parity bit set.
    localparam logic [WORD_W-1:0] RST_WORD = {1'b1, {(WORD_W-1){1'b0}}};
endpackage

// File: rtl/qlin_encoder.sv
// Module: qlin_encoder
// Maps an unsigned GeV value onto a quad-linear code. It selects the smallest
// range whose shifted value fits the mantissa, and saturates to all ones when
// none fits. Purely combinational. Assumes VAL_W > MANT_W.
module qlin_encoder
    import esum_qlin_pkg::*;
#(
    parameter int VAL_W = 12
) (
    input  logic [VAL_W-1:0] val,
    output qcode_t           code
);
    logic [VAL_W-1:0] sh;

    // Range search: walk from coarse to fine so the finest fitting range wins.
    always_comb begin
        code.rng  = '1;
        code.mant = '1;
        sh        = '0;
        for (int r = N_RANGES - 1; r >= 0; r--) begin
            sh = val >> (r * RANGE_STEP);
            if (sh[VAL_W-1:MANT_W] == '0) begin
                code.rng  = RANGE_W'(r);
                code.mant = sh[MANT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/xy_to_gev.sv
// Module: xy_to_gev
// Converts a signed fixed-point vector component into an unsigned whole-GeV
// magnitude. The absolute value is taken first, then the fraction bits are
// truncated. The most negative input maps to 2^(IN_W-1) without overflow.
module xy_to_gev #(
    parameter int IN_W   = 14,
    parameter int FRAC_W = 2,
    localparam int OUT_W = IN_W - FRAC_W
) (
    input  logic [IN_W-1:0]  comp,
    output logic [OUT_W-1:0] gev
);
    logic [IN_W-1:0] mag;

    // Magnitude: two's-complement negate when the sign bit is set.
    always_comb begin
        mag = comp[IN_W-1] ? (~comp + IN_W'(1)) : comp;
    end

    // Truncate the fraction bits to reach 1 GeV per LSB.
    always_comb begin
        gev = mag[IN_W-1:FRAC_W];
    end
endmodule

// File: rtl/esum_qlin_packer.sv
// Module: esum_qlin_packer (top)
// Encodes ET, |EX| and |EY| into quad-linear codes, packs them as
// {parity, EY, EX, ET} and registers the word with one cycle of latency.
// Reset is synchronous and active low.
module esum_qlin_packer
    import esum_qlin_pkg::*;
#(
    parameter int ET_W   = 12,
    parameter int XY_W   = 14,
    parameter int XY_FRAC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ET_W-1:0]   et_in,
    input  logic [XY_W-1:0]   ex_in,
    input  logic [XY_W-1:0]   ey_in,
    output logic [WORD_W-1:0] word_out
);
    localparam int XY_GEV_W = XY_W - XY_FRAC;

    qcode_t                codes [N_SUMS];
    logic [N_SUMS*CODE_W-1:0] packed_codes;
    logic [WORD_W-1:0]     word_d;
    logic [XY_W-1:0]       xy_in [2];

    // Route the two vector components into an array for the generate loop.
    always_comb begin
        xy_in[0] = ex_in;
        xy_in[1] = ey_in;
    end

    qlin_encoder #(.VAL_W(ET_W)) u_enc_et (
        .val  (et_in),
        .code (codes[0])
    );

    for (genvar g = 0; g < 2; g++) begin : g_xy
        logic [XY_GEV_W-1:0] gev;

        xy_to_gev #(.IN_W(XY_W), .FRAC_W(XY_FRAC)) u_mag (
            .comp (xy_in[g]),
            .gev  (gev)
        );

        qlin_encoder #(.VAL_W(XY_GEV_W)) u_enc (
            .val  (gev),
            .code (codes[g+1])
        );
    end

    // Pack the codes in field order and append the odd-parity bit.
    always_comb begin
        for (int i = 0; i < N_SUMS; i++) begin
            packed_codes[i*CODE_W +: CODE_W] = codes[i];
        end
        word_d = {~(^packed_codes), packed_codes};
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_out <= RST_WORD;
        else        word_out <= word_d;
    end
endmodule

// File: rtl/esum_qlin_checker.sv
// Module: esum_qlin_checker
// Properties on the packer's ports, attached through bind. Simulation only.
module esum_qlin_checker
    import esum_qlin_pkg::*;
#(
    parameter int ET_W = 12,
    parameter int XY_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ET_W-1:0]   et_in,
    input logic [XY_W-1:0]   ex_in,
    input logic [XY_W-1:0]   ey_in,
    input logic [WORD_W-1:0] word_out
);
    logic armed = 1'b0;
    logic rst_d = 1'b1;

    // Track whether one edge has passed and what reset was at the previous edge.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
        rst_d <= rst_n;
    end

    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(word_out) % 2) == 1); // R6

    AST_ET_RANGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out[7:6] != 2'd0) |-> (word_out[5:0] >= 6'd16)); // R3

    AST_EX_RANGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out[15:14] != 2'd0) |-> (word_out[13:8] >= 6'd16)); // R3

    AST_EY_RANGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out[23:22] != 2'd0) |-> (word_out[21:16] >= 6'd16)); // R3

    AST_SMALL_ET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (et_in < ET_W'(64)) |=> (word_out[7:0] == {2'b00, $past(et_in[5:0])})); // R7

    AST_EX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_in == '0) |=> (word_out[15:8] == 8'h00)); // R2

    AST_RESET_WORD: assert property (@(posedge clk)
        (armed && !rst_d) |-> (word_out == RST_WORD)); // R8
endmodule

bind esum_qlin_packer esum_qlin_checker #(.ET_W(ET_W), .XY_W(XY_W)) u_chk (.*);

// File: tb/tb_esum_qlin_packer.sv
`timescale 1ns/1ps
module tb_esum_qlin_packer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] et_n = '0;
    logic [13:0] ex_n = '0, ey_n = '0;
    logic [13:0] et_w = '0;
    logic [15:0] ex_w = '0, ey_w = '0;
    logic [24:0] word_n, word_w;
    logic [24:0] prev_n = 25'h1000000;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    esum_qlin_packer dut (.clk(clk), .rst_n(rst_n), .et_in(et_n),
        .ex_in(ex_n), .ey_in(ey_n), .word_out(word_n));

    esum_qlin_packer #(.ET_W(14), .XY_W(16)) dut_w (.clk(clk), .rst_n(rst_n),
        .et_in(et_w), .ex_in(ex_w), .ey_in(ey_w), .word_out(word_w));

    // Behavioural model of one code from a whole-GeV value.
    function automatic logic [7:0] enc(int v);
        if (v >= 4096) return 8'hFF;
        for (int r = 0; r < 4; r++)
            if ((v >> (2 * r)) < 64) return {2'(r), 6'(v >> (2 * r))};
        return 8'hFF;
    endfunction

    function automatic int gev(int x);
        int m;
        m = (x < 0) ? -x : x;
        return m >> 2;
    endfunction

    function automatic logic [24:0] model(int et, int ex, int ey);
        logic [23:0] low;
        low = {enc(gev(ey)), enc(gev(ex)), enc(et)};
        return {~(^low), low};
    endfunction

    task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply values at a falling edge, confirm hold (R7), then check after the edge.
    task automatic step(int et, int ex, int ey, string tag);
        logic [24:0] exp_n, exp_w;
        et_n = 12'(et); ex_n = 14'(ex); ey_n = 14'(ey);
        et_w = 14'(et); ex_w = 16'(ex); ey_w = 16'(ey);
        exp_n = model(int'(et_n), int'($signed(ex_n)), int'($signed(ey_n)));
        exp_w = model(int'(et_w), int'($signed(ex_w)), int'($signed(ey_w)));
        #1;
        check("R7 hold", word_n, prev_n);
        @(posedge clk);
        @(negedge clk);
        check(tag, word_n, exp_n);
        check({tag, " wide"}, word_w, exp_w);
        checks++;
        if ((($countones(word_n)) % 2) != 1) begin
            errors++;
            $display("FAIL R6: actual %h expected odd weight", word_n);
        end
        prev_n = word_n;
    endtask

    initial begin
        #(5 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", word_n, 25'h1000000);
        // R8: inputs applied during reset are ignored.
        et_n = 12'd500; ex_n = 14'd4000; et_w = 14'd500;
        @(posedge clk); @(negedge clk);
        check("R8 reset ignores inputs", word_n, 25'h1000000);
        check("R8 reset wide", word_w, 25'h1000000);
        et_n = '0; ex_n = '0; et_w = '0; ex_w = '0;
        rst_n = 1'b1;
        step(0, 0, 0, "R1 zero");
        step(63, 0, 0, "R1 edge fine");
        step(64, 0, 0, "R1 R3 first coarse");
        step(255, 0, 0, "R1 range1 top");
        step(256, 0, 0, "R1 range2 start");
        step(1023, 0, 0, "R1 range2 top");
        step(1024, 0, 0, "R1 range3 start");
        step(4095, 0, 0, "R1 max");
        step(0, 252, 3, "R2 positive fine");
        step(0, 256, -256, "R2 sign ignored");
        step(0, -1, 1, "R2 minus one");
        step(0, -8192, 8191, "R2 extremes");
        step(37, 4000, -4000, "R5 field order");
        step(4096, -32768, 32767, "R4 saturation");
        step(16383, 0, -20000, "R4 saturation max");
        for (int i = 0; i < 300; i++)
            step(int'($urandom_range(0, 16383)), int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768, "R1 R2 random");
        // R8: reset mid-run returns the reset word.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 mid-run reset", word_n, 25'h1000000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule